// File: doc/BRIEF.md
# Serial NOR Flash Command Front End with Write-Enable Gating

This block is the command front end of a serial NOR flash device. It acts as an SPI slave in mode 0. It brings the serial clock, chip select and data input into the system clock domain and assembles the first byte of each chip-select frame into an instruction. It decodes write enable, write disable, read status, write status, page program, sector erase and bulk erase. Bits are sampled on rising serial clock edges and shifted out on falling edges, most significant bit first.

The block holds a write enable latch and a write-in-progress flag. A write-type instruction runs only when the latch is already set, and only when chip select rises on a byte boundary. Each write-type instruction starts a busy countdown of its own length, counted in system clock cycles. This countdown stands in for the array timing. When the countdown ends, the busy flag clears and the latch clears with it, so every write-type operation needs a fresh write enable. The status byte can be read at any time, including during a busy cycle. It is re-sampled at every byte boundary for as long as chip select stays low.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Opcode 0x06 sets the write enable latch (status bit 1). This happens only when chip select rises after exactly 8 bits. A frame with more or fewer bits leaves the latch unchanged.
- R2: Opcode 0x04, framed as exactly 8 bits, clears the write enable latch.
- R3: Opcodes 0x02 (page program), 0xD8 (sector erase), 0xC7 (bulk erase) and 0x01 (write status) are ignored when the latch is clear. Ignored means no busy cycle starts and the status is unchanged.
- R4: A write-type instruction whose frame ends part-way through a byte is discarded. No busy cycle starts and the latch keeps its value.
- R5: An accepted write-type instruction sets the write-in-progress flag (status bit 0). The flag stays set for that command's configured number of system clock cycles. When the flag clears, the latch clears too.
- R6: While write-in-progress is set, every instruction except read status is ignored. This includes write disable, write enable and write status.
- R7: Opcode 0x05 drives the status byte on the serial output, MSB first, changing on falling clock edges. The byte is re-sampled live at each byte boundary and repeats until chip select rises. This also works during a busy cycle.
- R8: Write status takes the first data byte after the opcode. Its bits 7..2 become status bits 7..2 when the busy cycle completes. Status bits 1..0 cannot be written. A write status frame with no data byte is ignored.
- R9: The output enable stays low while the instruction byte is shifted in, and whenever chip select is high.
- R10: After reset the status byte reads 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |

## Verification
Read status is tried with single-byte reads and with a three-byte read in one frame, which separates a one-shot output from the repeating live byte. Write enable is sent both cleanly framed and with a ninth bit, which separates a byte-count check from plain opcode matching. Every write-type opcode is sent with the latch clear, with the latch set, and cut off mid-byte. The status is then read during the busy window and again after it, which shows whether write-in-progress, the latch and the written status bits change at the right moment. A write disable and a write status sent during a bulk erase show that instructions are blocked while busy.

// File: rtl/flash_cmd_pkg.sv
// Package: opcodes and the decoded command type shared by the front end.
package flash_cmd_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'hD8;
    localparam logic [7:0] OP_BE   = 8'hC7;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_PP,
        CMD_SE,
        CMD_BE
    } cmd_e;

    // Map an instruction byte to a command; unknown bytes give CMD_NONE.
    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OP_WREN: decode_op = CMD_WREN;
            OP_WRDI: decode_op = CMD_WRDI;
            OP_RDSR: decode_op = CMD_RDSR;
            OP_WRSR: decode_op = CMD_WRSR;
            OP_PP:   decode_op = CMD_PP;
            OP_SE:   decode_op = CMD_SE;
            OP_BE:   decode_op = CMD_BE;
            default: decode_op = CMD_NONE;
        endcase
    endfunction

    // True for commands that need the latch and start a busy cycle.
    function automatic logic is_write_cmd(input cmd_e c);
        is_write_cmd = (c == CMD_WRSR) || (c == CMD_PP) ||
                       (c == CMD_SE) || (c == CMD_BE);
    endfunction

endpackage

// File: rtl/fcc_sync.sv
// Module: fcc_sync
// Brings a vector of asynchronous inputs into the clk domain through a
// chain of STAGES flops per bit. Assumes each bit is stable for several
// clk cycles between changes, as an SPI clock slower than clk gives.
module fcc_sync #(
    parameter int unsigned       W       = 3,
    parameter int unsigned       STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Shift each input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_async;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/fcc_serdes.sv
// Module: fcc_serdes
// Bit engine. Samples MOSI on synchronized SCK rising edges, counts bits
// and bytes within a frame, and shifts the status byte out MSB first on
// falling edges while a read is active. At each byte boundary it reloads
// the live status. Assumes the inputs are already synchronized.
module fcc_serdes #(
    parameter int unsigned NB_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_s,
    input  logic            cs_fall,
    input  logic            sck_rise,
    input  logic            sck_fall,
    input  logic            mosi_s,
    input  logic            rd_active,
    input  logic [7:0]      status_live,
    output logic            byte_valid,
    output logic [7:0]      byte_data,
    output logic [NB_W-1:0] nbytes,
    output logic            on_boundary,
    output logic            miso,
    output logic            miso_oe
);

    localparam logic [NB_W-1:0] NB_MAX = '1;

    logic [2:0] bitcnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;

    // Receive: shift in bits and count bits and bytes within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            rx_sh      <= '0;
            nbytes     <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (cs_fall) begin
                bitcnt <= '0;
                nbytes <= '0;
            end else if (sck_rise && !cs_n_s) begin
                rx_sh  <= {rx_sh[6:0], mosi_s};
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    if (nbytes != NB_MAX) nbytes <= nbytes + 1'b1;
                end
            end
        end
    end

    // Transmit: load live status at byte boundaries, otherwise shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            miso_oe <= 1'b0;
        end else if (cs_n_s) begin
            miso_oe <= 1'b0;
        end else if (sck_fall && rd_active) begin
            miso_oe <= 1'b1;
            if (bitcnt == 3'd0) tx_sh <= status_live;
            else                tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign byte_data   = rx_sh;
    assign on_boundary = (bitcnt == 3'd0);
    assign miso        = miso_oe & tx_sh[7];

    AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !$past(cs_n_s)) else $error("oe outside frame"); // R9
    AST_OE_NOT_IN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && !cs_n_s) |-> (nbytes != '0)) else $error("oe during opcode"); // R9

endmodule

// File: rtl/fcc_busy_timer.sv
// Module: fcc_busy_timer
// Write-in-progress countdown. A start pulse loads the duration chosen by
// the command kind; busy stays high for exactly that many clk cycles and a
// one-cycle done pulse follows. Assumes every duration is at least 1 and
// that start never arrives while busy.
module fcc_busy_timer
    import flash_cmd_pkg::*;
#(
    parameter int unsigned T_WRSR = 200,
    parameter int unsigned T_PP   = 300,
    parameter int unsigned T_SE   = 400,
    parameter int unsigned T_BE   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cmd_e kind,
    output logic busy,
    output logic done
);

    localparam int unsigned T_MAX1 = (T_WRSR > T_PP) ? T_WRSR : T_PP;
    localparam int unsigned T_MAX2 = (T_SE > T_BE) ? T_SE : T_BE;
    localparam int unsigned T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Select the cycle count for the command being started.
    always_comb begin
        case (kind)
            CMD_WRSR: load_val = CNT_W'(T_WRSR);
            CMD_SE:   load_val = CNT_W'(T_SE);
            CMD_BE:   load_val = CNT_W'(T_BE);
            default:  load_val = CNT_W'(T_PP);
        endcase
    end

    // Count down while busy and flag completion for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt  <= load_val;
                busy <= 1'b1;
            end else if (busy) begin
                if (cnt == CNT_W'(1)) begin
                    cnt  <= '0;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_BUSY_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0)) else $error("busy with empty count"); // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy) else $error("start while busy"); // R6

endmodule

// File: rtl/fcc_cmd_ctrl.sv
// Module: fcc_cmd_ctrl
// Command layer. It latches the decoded first byte of a frame and keeps the
// write enable latch and the writable status bits. When chip select rises
// it decides whether the frame executes. Assumes the byte and frame
// signals come from fcc_serdes and busy/done from fcc_busy_timer.
module fcc_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int unsigned NB_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_rise,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    input  logic [NB_W-1:0] nbytes,
    input  logic            on_boundary,
    input  logic            busy,
    input  logic            done,
    output logic            rd_active,
    output logic            start,
    output cmd_e            cmd,
    output logic [7:0]      status
);

    logic       wel;
    logic [5:0] user_bits;
    logic [5:0] wr_hold;
    logic [5:0] wr_pend;
    logic       pend_valid;
    logic       exact_one;
    logic       set_wel;
    logic       clr_wel;
    cmd_e       dec;

    assign dec       = decode_op(byte_data);
    assign exact_one = on_boundary && (nbytes == NB_W'(1));

    // Decide at chip-select rise whether the captured command executes.
    always_comb begin
        start   = 1'b0;
        set_wel = 1'b0;
        clr_wel = 1'b0;
        if (cs_rise && !busy) begin
            case (cmd)
                CMD_WREN: set_wel = exact_one;
                CMD_WRDI: clr_wel = exact_one;
                CMD_WRSR: start   = wel && on_boundary && (nbytes >= NB_W'(2));
                CMD_PP, CMD_SE, CMD_BE: start = wel && on_boundary;
                default: ;
            endcase
        end
    end

    // Capture the command and write-status data byte during the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd       <= CMD_NONE;
            rd_active <= 1'b0;
            wr_hold   <= '0;
        end else if (cs_rise) begin
            cmd       <= CMD_NONE;
            rd_active <= 1'b0;
        end else if (byte_valid) begin
            if (nbytes == NB_W'(1)) begin
                cmd       <= (busy && dec != CMD_RDSR) ? CMD_NONE : dec;
                rd_active <= (dec == CMD_RDSR);
            end else if (nbytes == NB_W'(2) && cmd == CMD_WRSR) begin
                wr_hold <= byte_data[7:2];
            end
        end
    end

    // Keep the latch and writable status bits; apply pending write at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel        <= 1'b0;
            user_bits  <= '0;
            wr_pend    <= '0;
            pend_valid <= 1'b0;
        end else begin
            if (set_wel) wel <= 1'b1;
            if (clr_wel) wel <= 1'b0;
            if (start) begin
                pend_valid <= (cmd == CMD_WRSR);
                wr_pend    <= wr_hold;
            end
            if (done) begin
                wel        <= 1'b0;
                pend_valid <= 1'b0;
                if (pend_valid) user_bits <= wr_pend;
            end
        end
    end

    assign status = {user_bits, wel, busy};

    AST_WEL_RISES_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise)) else $error("latch set mid-frame"); // R1
    AST_START_NEEDS_WRITE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> is_write_cmd(cmd)) else $error("start on non-write cmd"); // R3

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: flash_cmd_ctrl (top)
// SPI mode-0 command front end for a serial NOR flash. It synchronizes the
// SPI pins into clk, finds SCK and CS edges, and connects the bit engine,
// the command layer and the busy timer. Assumes clk runs at least 4x SCK.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned T_WRSR      = 200,
    parameter int unsigned T_PP        = 300,
    parameter int unsigned T_SE        = 400,
    parameter int unsigned T_BE        = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);

    localparam int unsigned NB_W = 3;

    logic [2:0] pins_s;
    logic       sck_s, cs_n_s, mosi_s;
    logic       sck_d, cs_d;
    logic       sck_rise, sck_fall, cs_rise, cs_fall;
    logic       byte_valid, on_boundary, rd_active, start, busy, done;
    logic [7:0] byte_data, status;
    logic [NB_W-1:0] nbytes;
    cmd_e       cmd;

    fcc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_mosi, spi_cs_n, spi_sck}),
        .q       (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[2];

    // Remember the previous synchronized SCK and CS for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;
    assign cs_fall  = ~cs_n_s & cs_d;

    fcc_serdes #(.NB_W(NB_W)) u_serdes (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (cs_n_s),
        .cs_fall     (cs_fall),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .mosi_s      (mosi_s),
        .rd_active   (rd_active),
        .status_live (status),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .nbytes      (nbytes),
        .on_boundary (on_boundary),
        .miso        (spi_miso),
        .miso_oe     (spi_miso_oe)
    );

    fcc_cmd_ctrl #(.NB_W(NB_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_rise     (cs_rise),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .nbytes      (nbytes),
        .on_boundary (on_boundary),
        .busy        (busy),
        .done        (done),
        .rd_active   (rd_active),
        .start       (start),
        .cmd         (cmd),
        .status      (status)
    );

    fcc_busy_timer #(.T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .kind  (cmd),
        .busy  (busy),
        .done  (done)
    );

    AST_DONE_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (status[1:0] == 2'b00)) else $error("latch survives completion"); // R5
    AST_BUSY_BLOCKS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !$rose(status[1])) else $error("latch set while busy"); // R6
    AST_START_HAS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(status[1])) else $error("busy without latch"); // R3

endmodule

// File: tb/test_flash_cmd_ctrl.sv
// Scoreboard bench: rdsr() pushes expected status bytes, the monitor
// compares each byte as it is shifted out on spi_miso.
module test_flash_cmd_ctrl;

    localparam int H = 4;   // SCK half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic spi_miso_oe;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: collect output bits while driven, compare whole bytes.
    int         mon_n = 0;
    logic [7:0] mon_sh = '0;
    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (!spi_cs_n && !spi_sck) begin
            mon_n = 0;
        end else if (spi_sck && !spi_cs_n && spi_miso_oe) begin
            mon_sh = {mon_sh[6:0], spi_miso};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected byte", mon_sh, 8'h00);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mon_sh == e.val, e.tag, mon_sh, e.val);
                end
            end
        end
    end

    // Driver: one chip-select frame of n bytes plus xb extra zero bits.
    task automatic frame(input logic [7:0] d0, d1, d2, d3, d4,
                         input int n, input int xb);
        logic [7:0] d [5];
        bit oe_seen;
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3; d[4] = d4;
        oe_seen = 0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n * 8 + xb; i++) begin
            spi_mosi = (i < n * 8) ? d[i / 8][7 - (i % 8)] : 1'b0;
            repeat (H) @(negedge clk);
            spi_sck = 1'b1;
            if (i < 8 && spi_miso_oe) oe_seen = 1;
            repeat (H) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        check(!oe_seen, "R9 oe during opcode byte", {7'd0, oe_seen}, 8'h00);
        repeat (4 * H) @(negedge clk);
        check(spi_miso_oe == 1'b0, "R9 oe with cs high", {7'd0, spi_miso_oe}, 8'h00);
    endtask

    task automatic rdsr(input int n, input logic [7:0] exp, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = exp;
            e.tag = tag;
            exp_q.push_back(e);
        end
        frame(8'h05, 8'h00, 8'h00, 8'h00, 8'h00, n + 1, 0);
        check(exp_q.size() == 0, {tag, " missing read bytes"}, 8'(exp_q.size()), 8'h00);
        exp_q.delete();
    endtask

    task automatic wren();
        frame(8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_clk(5);
        check(spi_miso_oe == 1'b0, "R10 oe after reset", {7'd0, spi_miso_oe}, 8'h00);
        rdsr(1, 8'h00, "R10 status after reset");

        // R1 / R7: latch set, repeated live status in one frame
        wren();
        rdsr(3, 8'h02, "R1 R7 latch set, repeated read");

        // R2: write disable clears it
        frame(8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0);
        rdsr(1, 8'h00, "R2 latch cleared");

        // R3: page program without latch ignored
        frame(8'h02, 8'h00, 8'h10, 8'h00, 8'h5A, 5, 0);
        rdsr(1, 8'h00, "R3 program without latch");

        // R1: write enable with a ninth bit is not taken
        frame(8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1);
        rdsr(1, 8'h00, "R1 misframed enable");

        // R5: page program busy window then completion
        wren();
        frame(8'h02, 8'h00, 8'h10, 8'h00, 8'h5A, 5, 0);
        rdsr(1, 8'h03, "R5 program busy");
        wait_clk(400);
        rdsr(1, 8'h00, "R5 program done");

        // R8: write status applies bits 7..2 at completion
        wren();
        frame(8'h01, 8'hAB, 8'h00, 8'h00, 8'h00, 2, 0);
        rdsr(1, 8'h03, "R8 status write still pending");
        wait_clk(300);
        rdsr(1, 8'hA8, "R8 status bits written");

        // R4: sector erase cut mid-byte is discarded, latch kept
        wren();
        frame(8'hD8, 8'h01, 8'h00, 8'h00, 8'h00, 4, 3);
        rdsr(1, 8'hAA, "R4 partial-byte erase");

        // R6: bulk erase; write disable and write status during busy ignored
        frame(8'hC7, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0);
        frame(8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0);
        rdsr(1, 8'hAB, "R6 disable ignored while busy");
        frame(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 2, 0);
        wait_clk(600);
        rdsr(1, 8'hA8, "R6 R5 erase done, status write ignored");

        // R8: write status without data byte ignored
        wren();
        frame(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 1, 0);
        rdsr(1, 8'hAA, "R8 status write without data");

        // R3 / R5: sector erase accepted then completes
        frame(8'hD8, 8'h02, 8'h00, 8'h00, 8'h00, 4, 0);
        rdsr(1, 8'hAB, "R3 erase accepted");
        wait_clk(500);
        rdsr(1, 8'hA8, "R5 erase done");

        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule